// File: doc/BRIEF.md
# Serial Flash Target Model with Top-Aligned Write Protection

This block behaves as a serial flash memory on a mode-0 SPI link, for use as a device model when testing flash host controllers. The host selects it by pulling the active-low select low. It shifts a one-byte command plus any address and data bytes in on MOSI, and it receives read data and status on MISO. The model runs on a system clock that is several times faster than the serial clock. It samples select, serial clock and MOSI on that system clock and detects their edges there. These inputs are assumed to be already synchronous to the system clock.

A status byte holds a protection lock, a four-bit protect field, a write-enable latch and a busy flag. Program and erase operations hold busy high for a fixed number of system clock cycles. Each byte program consumes the write-enable latch, so every program needs its own preceding write enable. The low three protect bits choose a protected region that is aligned to the top of a 2 MiB address map and that grows as the value rises. Writes into that region are dropped without any error.

Address decoding uses 21 of the 24 address bits sent, so bits 23..21 are ignored. The backing storage holds 2^MEM_AW bytes (256 by default), and addresses alias modulo that size.

Top module: `flash_target`

## Requirements
- R1: Status byte layout is bit 7 lock, bit 6 always 0, bits 5..2 protect field (bit 5 highest), bit 1 write-enable latch, bit 0 busy. After reset the status byte is 0x00 and MISO is low. Opcode 0x05 returns the live status byte MSB first, repeatedly for as long as select stays low, and it works while busy.
- R2: Opcode 0x06 sets the latch and opcode 0x04 clears it. Each takes effect when select rises after exactly one byte.
- R3: Opcode 0x01 plus one data byte writes the status register only if the latch is set. It updates the lock and protect bits from the same bit positions of the data byte, and it clears the latch.
- R4: While the lock bit is 1, a status write leaves the protect field unchanged. The lock bit itself still takes data bit 7.
- R5: Opcode 0x02, then address bytes [23:16], [15:8] and [7:0], then one data byte, programs exactly one byte, but only when the latch is set. It clears the latch and holds busy for PROG_CYCLES.
- R6: A program or status write is discarded, with the latch left as it was, when select rises after any byte count other than 5 (program) or 2 (status write).
- R7: Let P be status bits 4..2. P=0 protects nothing. P=1 protects 0x1F0000..0x1FFFFF, P=2 protects from 0x1E0000, P=3 from 0x1C0000, P=4 from 0x180000 and P=5 from 0x100000, each region running to the top. P=6 and P=7 protect everything.
- R8: A program to a protected address clears the latch, leaves the storage unchanged and does not set busy.
- R9: Opcode 0xC7 with the latch set sets every byte to 0xFF and holds busy for ERASE_CYCLES. If P is not 0, the erase is refused: the latch clears and no byte changes.
- R10: While busy, every opcode other than 0x05 is ignored. A read issued in that state returns 0x00 bytes.
- R11: Opcode 0x03 plus three address bytes streams bytes MSB first from that address, changing MISO on falling serial clock edges. The address wraps from 0x1FFFFF to 0x000000.
- R12: Opcode 0x0B works like 0x03, but one dummy byte follows the address before the first data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idles low (mode 0) |
| mosi | input | 1 | Serial data from host, sampled on rising sck |
| miso | output | 1 | Serial data to host, updated after falling sck |

## Verification
A wrong latch or busy state appears at the ports on the next status read. Expected status bytes are compared immediately after each command frame, so the error shows within one frame. A wrong protect decode or a wrong address assembly does not appear until the affected location is read back. The bench therefore re-reads every programmed, blocked or erase-refused location, in the frame that follows the busy period. Read streaming faults, such as a missing dummy byte, a wrong wrap or a wrong edge for updating MISO, are caught at the first streamed byte that should differ.

// File: rtl/flash_tgt_pkg.sv
// Package: command codes and field sizes shared by the flash target model.
// Assumes: one-byte opcodes, three address bytes sent MSB first.
package flash_tgt_pkg;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_ERASE = 8'hC7;

    localparam int ADDR_BYTES = 3;
    localparam int CNT_W      = 3;          // byte counter, saturates at 7
    localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LEN_WRSR = CNT_W'(2);
    localparam logic [CNT_W-1:0] LEN_PROG = CNT_W'(ADDR_BYTES + 2);
    localparam logic [CNT_W-1:0] LEN_READ = CNT_W'(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LEN_FRD  = CNT_W'(ADDR_BYTES + 2);
endpackage

// File: rtl/spi_target_shift.sv
// Module: mode-0 serial shifter for the target side.
// Does: detects sck/cs_n edges on clk, assembles received bytes, counts
// whole bytes per frame and shifts tx_byte out MSB first on falling sck.
// Assumes: cs_n, sck, mosi synchronous to clk; sck at least 2 clk per phase.
module spi_target_shift
    import flash_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic [7:0]       tx_byte,
    output logic             miso,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             tx_load,
    output logic             frame_end,
    output logic             frame_whole
);
    logic       sck_q, cs_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh;
    logic       sck_rise, sck_fall;

    // Edge strobes and byte-level events derived from the sampled pins.
    always_comb begin
        sck_rise    = sck & ~sck_q & ~cs_n;
        sck_fall    = ~sck & sck_q & ~cs_n;
        byte_done   = sck_rise && (bit_cnt == 3'd7);
        rx_byte     = {rx_sh[6:0], mosi};
        tx_load     = sck_fall && (bit_cnt == 3'd0) && (byte_cnt != '0);
        frame_end   = cs_n & ~cs_q;
        frame_whole = (bit_cnt == 3'd0);
        miso        = tx_sh[7];
    end

    // Pin history, receive shifting, counters and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                tx_sh    <= '0;
            end else if (sck_rise) begin
                rx_sh   <= rx_byte;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7 && byte_cnt != '1)
                    byte_cnt <= byte_cnt + CNT_W'(1);
            end else if (sck_fall) begin
                tx_sh <= tx_load ? tx_byte : {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/flash_prot_decode.sv
// Module: top-aligned protection decode.
// Does: flags an address inside the region chosen by a 3-bit protect value;
// value v in 1..UNITS_W+1 protects the top 2^(v-1) units, larger values all.
// Assumes: UNIT_AW < FLASH_AW.
module flash_prot_decode #(
    parameter int FLASH_AW = 21,
    parameter int UNIT_AW  = 16
) (
    input  logic [2:0]          prot_sel,
    input  logic [FLASH_AW-1:0] addr,
    output logic                addr_prot,
    output logic                any_prot
);
    localparam int UNITS_W = FLASH_AW - UNIT_AW;
    logic [FLASH_AW:0] span;
    logic [FLASH_AW:0] floor_addr;

    // Size of the protected region in bytes and its lowest address.
    always_comb begin
        if (prot_sel == 3'd0)
            span = '0;
        else if (int'(prot_sel) > UNITS_W)
            span = (FLASH_AW+1)'(1) << FLASH_AW;
        else
            span = (FLASH_AW+1)'(1) << (UNIT_AW + int'(prot_sel) - 1);
        floor_addr = ((FLASH_AW+1)'(1) << FLASH_AW) - span;
        addr_prot  = ({1'b0, addr} >= floor_addr);
        any_prot   = (prot_sel != 3'd0);
    end
endmodule

// File: rtl/flash_byte_store.sv
// Module: byte storage with one-byte write and whole-array erase to 0xFF.
// Does: asynchronous read, synchronous write/erase; erase wins over write.
// Assumes: contents undefined until first erase or write (no reset).
module flash_byte_store #(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << MEM_AW;
    logic [7:0] mem [DEPTH];

    // Erase fills every entry; otherwise apply a single-byte write.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read port for the transmit path.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_target.sv
// Module: serial flash target model (top).
// Does: decodes commands from the shifter, keeps the status register,
// executes program/erase/status-write at frame end, times busy, streams reads.
// Assumes: clk several times faster than sck; storage aliases modulo 2^MEM_AW.
module flash_target
    import flash_tgt_pkg::*;
#(
    parameter int FLASH_AW     = 21,
    parameter int UNIT_AW      = 16,
    parameter int MEM_AW       = 8,
    parameter int PROG_CYCLES  = 400,
    parameter int ERASE_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int BUSY_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int BUSY_W   = $clog2(BUSY_MAX + 1);

    logic             byte_done, tx_load, frame_end, frame_whole;
    logic [7:0]       rx_byte, tx_byte, mem_q, status;
    logic [CNT_W-1:0] byte_cnt;

    logic [7:0]          opcode;
    logic                cmd_live;
    logic [FLASH_AW-1:0] addr_q, addr_next;
    logic [7:0]          data_q;
    logic [MEM_AW-1:0]   rd_ptr;
    logic                lock_q, wel_q;
    logic [3:0]          bp_q;
    logic [BUSY_W-1:0]   busy_cnt;
    logic                busy, rd_phase, exec, addr_prot, any_prot, mem_we, erase_go;

    spi_target_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .tx_byte(tx_byte), .miso(miso), .byte_done(byte_done), .rx_byte(rx_byte),
        .byte_cnt(byte_cnt), .tx_load(tx_load), .frame_end(frame_end),
        .frame_whole(frame_whole)
    );

    flash_prot_decode #(.FLASH_AW(FLASH_AW), .UNIT_AW(UNIT_AW)) u_prot (
        .prot_sel(bp_q[2:0]), .addr(addr_q), .addr_prot(addr_prot), .any_prot(any_prot)
    );

    flash_byte_store #(.MEM_AW(MEM_AW)) u_store (
        .clk(clk), .wr_en(mem_we), .wr_addr(addr_q[MEM_AW-1:0]), .wr_data(data_q),
        .erase(erase_go), .rd_addr(rd_ptr), .rd_data(mem_q)
    );

    // Status byte, read phase, transmit source and frame-end actions.
    always_comb begin
        busy      = (busy_cnt != '0);
        status    = {lock_q, 1'b0, bp_q, wel_q, busy};
        addr_next = {addr_q[FLASH_AW-9:0], rx_byte};
        rd_phase  = cmd_live && (((opcode == OP_READ)  && (byte_cnt >= LEN_READ)) ||
                                 ((opcode == OP_FREAD) && (byte_cnt >= LEN_FRD)));
        if (rd_phase)
            tx_byte = mem_q;
        else if (cmd_live && opcode == OP_RDSR)
            tx_byte = status;
        else
            tx_byte = 8'h00;
        exec     = frame_end && frame_whole && cmd_live && !busy;
        mem_we   = exec && (opcode == OP_PROG) && (byte_cnt == LEN_PROG) && wel_q && !addr_prot;
        erase_go = exec && (opcode == OP_ERASE) && (byte_cnt == LEN_CMD) && wel_q && !any_prot;
    end

    // Command capture, read pointer, status register and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode   <= '0;
            cmd_live <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            rd_ptr   <= '0;
            lock_q   <= 1'b0;
            wel_q    <= 1'b0;
            bp_q     <= '0;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - BUSY_W'(1);
            if (byte_done) begin
                if (byte_cnt == '0) begin
                    opcode   <= rx_byte;
                    cmd_live <= !busy || (rx_byte == OP_RDSR);
                end else begin
                    if (byte_cnt <= CNT_W'(ADDR_BYTES)) addr_q <= addr_next;
                    if (byte_cnt == CNT_W'(ADDR_BYTES)) rd_ptr <= addr_next[MEM_AW-1:0];
                    if (byte_cnt == CNT_W'(1) || byte_cnt == CNT_W'(ADDR_BYTES + 1))
                        data_q <= rx_byte;
                end
            end
            if (tx_load && rd_phase) rd_ptr <= rd_ptr + MEM_AW'(1);
            if (frame_end) cmd_live <= 1'b0;
            if (exec) begin
                case (opcode)
                    OP_WREN: if (byte_cnt == LEN_CMD) wel_q <= 1'b1;
                    OP_WRDI: if (byte_cnt == LEN_CMD) wel_q <= 1'b0;
                    OP_WRSR: if (byte_cnt == LEN_WRSR && wel_q) begin
                        lock_q <= data_q[7];
                        if (!lock_q) bp_q <= data_q[5:2];
                        wel_q  <= 1'b0;
                    end
                    OP_PROG: if (byte_cnt == LEN_PROG && wel_q) begin
                        wel_q <= 1'b0;
                        if (!addr_prot) busy_cnt <= BUSY_W'(PROG_CYCLES);
                    end
                    OP_ERASE: if (byte_cnt == LEN_CMD && wel_q) begin
                        wel_q <= 1'b0;
                        if (!any_prot) busy_cnt <= BUSY_W'(ERASE_CYCLES);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_target_chk.sv
// Module: assertion checker for flash_target, attached with bind.
// Does: checks latch, busy and lock ordering against frame boundaries.
// Assumes: signals connected by name from the flash_target scope.
module flash_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_end,
    input logic       wel,
    input logic       busy,
    input logic       lock,
    input logic [3:0] bp
);
    AST_WEL_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wel) |-> $past(frame_end)); // R2

    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wel) && $past(frame_end))); // R5

    AST_LOCK_HOLDS_BP: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(bp)); // R4

    AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy)); // R10

    AST_BUSY_KEEPS_BP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bp)); // R10
endmodule

bind flash_target flash_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .wel(wel_q),
    .busy(busy), .lock(lock_q), .bp(bp_q)
);

// File: tb/test_flash_target.sv
// Bench: scoreboard. Driver tasks push expected bytes into a queue,
// a monitor process pops and compares each byte the target returns.
module test_flash_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;      // clk cycles per sck phase
    localparam int MEM_AW     = 8;

    typedef logic [7:0] bq_t[$];
    typedef struct { logic [7:0] val; string req; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int   checks = 0, errors = 0;
    exp_t exp_q[$];
    logic [7:0] rx_val;
    event rx_ev;
    logic [7:0] model [1 << MEM_AW];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_target #(.MEM_AW(MEM_AW)) i_flash_target (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    // Monitor: compare each returned byte with the oldest expectation.
    always @(rx_ev) begin
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected byte actual=%02h expected=none", rx_val);
        end else begin
            e = exp_q.pop_front();
            if (rx_val !== e.val) begin
                errors++;
                $display("FAIL %s: actual=%02h expected=%02h", e.req, rx_val, e.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            tick(HALF);
            r[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cmd(input bq_t bytes);
        logic [7:0] r;
        tick(2); cs_n = 1'b0; tick(2);
        foreach (bytes[i]) xfer(bytes[i], r);
        tick(HALF); cs_n = 1'b1; tick(4);
    endtask

    task automatic read_expect(input bq_t hdr, input bq_t exp, input string req);
        logic [7:0] r;
        tick(2); cs_n = 1'b0; tick(2);
        foreach (hdr[i]) xfer(hdr[i], r);
        foreach (exp[i]) begin
            exp_q.push_back('{val: exp[i], req: req});
            xfer(8'h00, r);
            rx_val = r;
            -> rx_ev;
            tick(1);
        end
        tick(HALF); cs_n = 1'b1; tick(4);
    endtask

    task automatic stat_expect(input logic [7:0] s, input string req);
        read_expect('{8'h05}, '{s, s}, req);
    endtask

    task automatic wait_idle();
        logic [7:0] r;
        do begin
            tick(2); cs_n = 1'b0; tick(2);
            xfer(8'h05, r); xfer(8'h00, r);
            tick(HALF); cs_n = 1'b1; tick(4);
        end while (r[0]);
    endtask

    task automatic prog(input logic [23:0] a, input logic [7:0] d);
        cmd('{8'h06});
        cmd('{8'h02, a[23:16], a[15:8], a[7:0], d});
    endtask

    task automatic wrsr(input logic [7:0] d);
        cmd('{8'h06});
        cmd('{8'h01, d});
    endtask

    function automatic logic [7:0] m(input logic [23:0] a);
        return model[a[MEM_AW-1:0]];
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(5); rst_n = 1'b1; tick(3);
        // R1: reset state at the pins and in status
        checks++;
        if (miso !== 1'b0) begin errors++; $display("FAIL R1: miso actual=%b expected=0", miso); end
        stat_expect(8'h00, "R1 reset status");
        read_expect('{8'h05}, '{8'h00, 8'h00, 8'h00}, "R1 repeated status");

        // R2 latch set, R9 erase with busy
        cmd('{8'h06});
        stat_expect(8'h02, "R2 write enable");
        cmd('{8'hC7});
        stat_expect(8'h01, "R9 erase busy");
        wait_idle();
        foreach (model[i]) model[i] = 8'hFF;
        read_expect('{8'h03, 8'h00, 8'h00, 8'h10}, '{8'hFF, 8'hFF}, "R9 erased");

        // R5 program
        prog(24'h000010, 8'hA5);
        stat_expect(8'h01, "R5 busy after program");
        wait_idle(); model[8'h10] = 8'hA5;
        read_expect('{8'h03, 8'h00, 8'h00, 8'h10}, '{m(24'h10)}, "R5 programmed byte");
        // R5: no latch, no program
        cmd('{8'h02, 8'h00, 8'h00, 8'h11, 8'h3C});
        read_expect('{8'h03, 8'h00, 8'h00, 8'h11}, '{m(24'h11)}, "R5 program without latch");

        // R6 wrong count keeps latch, R2 write disable
        cmd('{8'h06});
        cmd('{8'h02, 8'h00, 8'h00, 8'h12});
        stat_expect(8'h02, "R6 short program");
        cmd('{8'h02, 8'h00, 8'h00, 8'h12, 8'h44, 8'h55});
        stat_expect(8'h02, "R6 long program");
        cmd('{8'h04});
        stat_expect(8'h00, "R2 write disable");
        read_expect('{8'h03, 8'h00, 8'h00, 8'h12}, '{m(24'h12)}, "R6 nothing written");

        // R10 busy ignores commands
        prog(24'h000013, 8'h5A);
        cmd('{8'h06});
        stat_expect(8'h01, "R10 latch ignored while busy");
        read_expect('{8'h03, 8'h00, 8'h00, 8'h10}, '{8'h00}, "R10 read ignored while busy");
        wait_idle(); model[8'h13] = 8'h5A;
        stat_expect(8'h00, "R10 idle again");

        // R12 fast read with dummy byte
        read_expect('{8'h0B, 8'h00, 8'h00, 8'h10, 8'h00},
                    '{m(24'h10), m(24'h11), m(24'h12), m(24'h13)}, "R12 fast read");

        // R11 wrap from top of map to zero
        prog(24'h1FFFFF, 8'h77); wait_idle(); model[8'hFF] = 8'h77;
        prog(24'h000000, 8'h88); wait_idle(); model[8'h00] = 8'h88;
        read_expect('{8'h03, 8'h1F, 8'hFF, 8'hFF}, '{8'h77, 8'h88}, "R11 wrap");

        // R3 status write, R7/R8 protection
        wrsr(8'h04);
        stat_expect(8'h04, "R3 status write");
        prog(24'h1F0000, 8'h11);
        stat_expect(8'h04, "R8 protected program no busy");
        read_expect('{8'h03, 8'h1F, 8'h00, 8'h00}, '{m(24'h1F0000)}, "R8 protected unchanged");
        prog(24'h1EFFFF, 8'h42); wait_idle(); model[8'hFF] = 8'h42;
        read_expect('{8'h03, 8'h1E, 8'hFF, 8'hFF}, '{m(24'h1EFFFF)}, "R7 below P=1 region");
        wrsr(8'h10);
        prog(24'h180020, 8'h99);
        stat_expect(8'h10, "R7 P=4 blocks 0x180020");
        read_expect('{8'h03, 8'h18, 8'h00, 8'h20}, '{m(24'h180020)}, "R7 P=4 unchanged");
        prog(24'h17FFF0, 8'h66); wait_idle(); model[8'hF0] = 8'h66;
        read_expect('{8'h03, 8'h17, 8'hFF, 8'hF0}, '{m(24'h17FFF0)}, "R7 below P=4 region");
        wrsr(8'h18);
        prog(24'h000030, 8'h12);
        read_expect('{8'h03, 8'h00, 8'h00, 8'h30}, '{m(24'h30)}, "R7 P=6 protects all");
        cmd('{8'h06}); cmd('{8'hC7});
        stat_expect(8'h18, "R9 erase refused");
        read_expect('{8'h03, 8'h00, 8'h00, 8'h10}, '{m(24'h10)}, "R9 data kept");

        // R4 lock holds protect field
        wrsr(8'h98);
        stat_expect(8'h98, "R4 lock set");
        wrsr(8'h80);
        stat_expect(8'h98, "R4 protect held under lock");
        wrsr(8'h00);
        stat_expect(8'h18, "R4 lock cleared");
        wrsr(8'h40);
        stat_expect(8'h00, "R1 bit 6 reads zero");
        cmd('{8'h06});
        cmd('{8'h01, 8'h04, 8'h08});
        stat_expect(8'h02, "R6 long status write");

        tick(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule